// File: doc/BRIEF.md
# External Interrupt Pin Sense Logic

This block watches four external interrupt request pins and turns each into a flagged interrupt request for the processor. Each pin is first passed through a two-flop synchronizer. A two-bit sense field per pin then selects one of four detection modes: low level, falling edge, rising edge or both edges. The pin's flag drives its interrupt request output. Arbitration between pins and vector generation happen elsewhere.

In an edge mode, the flag is held by a small per-pin state machine with three states. FL_IDLE means the flag is 0. FL_PEND means the flag is 1 and software has not yet read it as 1. FL_ARMED means the flag is 1 and a status read has already returned it as 1. The transitions are as follows:
- *set*: FL_IDLE goes to FL_PEND on a detected edge.
- *observe*: FL_PEND goes to FL_ARMED on a status read.
- *release*: FL_ARMED goes to FL_IDLE when software writes 0 to that flag bit.
- *accept*: FL_PEND or FL_ARMED goes to FL_IDLE when the acknowledge input is asserted.
- *re-set*: when a release or accept happens in the same cycle as a new edge, the machine goes to FL_PEND, so the set wins.
- *level override*: while a pin is in low-level mode, its machine is held in FL_IDLE.

In low-level mode the flag simply follows the inverted synchronized pin. In that mode the flag cannot be cleared by a write or by an acknowledge.

Software reaches the block through a single register port with a select line. Select 0 addresses the control register, which is readable and writable. In that register, bits [2n+1:2n] hold the sense field of pin n. Select 1 addresses the status register. Bits [3:0] hold the flags. Bits [7:4] hold the synchronized pin levels and are read-only.

Top module: `irq_sense_top`

## Requirements
- R1: After reset, the control register reads 0 (every pin in low-level mode), the synchronizer and previous-sample state read as high, and with all pins high the outputs `irq_o` are 0 and the status register reads 8'hF0.
- R2: Each pin passes through two flops before it is used. Status bit 4+n shows the level that pin n had two clock edges earlier.
- R3: With sense field 2'b00 (low level), `irq_o[n]` is 1 exactly while the synchronized pin is 0. Neither a status write nor `ack_i[n]` clears it.
- R4: With sense field 2'b01 (falling), 2'b10 (rising) or 2'b11 (both), an edge is detected by comparing the current and previous synchronized samples. The flag becomes 1 three clock edges after the pin changes, and an edge of the other polarity (for the single-edge modes) sets nothing.
- R5: An edge flag that was read as 1 (a status read with select 1) is cleared by a later status write with bit n equal to 0.
- R6: A status write with bit n equal to 0 has no effect on a flag that has not been read as 1 since it was set. Writing 1 to a status bit never sets a flag.
- R7: In an edge mode, `ack_i[n]` clears flag n in the following cycle.
- R8: If an edge arrives in the same cycle as a clear (write-after-read or acknowledge), the flag stays 1 and must again be read before a write can clear it.
- R9: The control register reads back the last value written to it with select 0 and changes only on such a write.
- R10: `irq_o[n]` always equals status bit n. `reg_rdata` is a combinational view of the register chosen by `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| ack_i | input | 4 | Per-pin interrupt accepted strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms flags read as 1 when select is 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 4 | Per-pin interrupt request |

## Verification
The hardest case to reach is the collision in which a new edge is detected in exactly the cycle that a write-after-read or an acknowledge clears the flag. The stimulus arms the flag with a status read and then drives the opposite pin level. It waits two clock edges, one for each synchronizer flop, and then asserts the zero write, so that the write and the edge detector's output meet at the same clock edge. A follow-up write without a fresh read confirms that the machine went back to the pending state rather than the armed one.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'b00,
        FL_PEND  = 2'b01,
        FL_ARMED = 2'b10
    } flag_st_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] sync_o
);
    logic [N_PINS-1:0] meta_q;
    logic [N_PINS-1:0] sync_q;

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[i] <= 1'b1;
                    sync_q[i] <= 1'b1;
                end else begin
                    meta_q[i] <= pin_i[i];
                    sync_q[i] <= meta_q[i];
                end
            end
        end
    endgenerate

    assign sync_o = sync_q;

    // Age counter used only by the check below.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    // R2: the synchronized level lags the pin by two edges.
    a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (sync_o == $past(pin_i, 2)));

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
    import irq_sense_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PINS-1:0]   lvl_i,
    input  logic [2*N_PINS-1:0] mode_i,
    output logic [N_PINS-1:0]   ev_o
);
    logic [N_PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl_i;
    end

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_det
            sense_e mode_w;
            assign mode_w = sense_e'(mode_i[2*i +: 2]);

            always_comb begin
                unique case (mode_w)
                    SENSE_LOW:  ev_o[i] = 1'b0;
                    SENSE_FALL: ev_o[i] = prev_q[i] & ~lvl_i[i];
                    SENSE_RISE: ev_o[i] = ~prev_q[i] & lvl_i[i];
                    SENSE_BOTH: ev_o[i] = prev_q[i] ^ lvl_i[i];
                    default:    ev_o[i] = 1'b0;
                endcase
            end

            // R4: an edge is only reported when the sample actually moved.
            a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
                ev_o[i] |-> (lvl_i[i] != prev_q[i]));
        end
    endgenerate

endmodule

// File: rtl/irq_flag_fsm.sv
module irq_flag_fsm
    import irq_sense_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode_i,
    input  logic   lvl_i,
    input  logic   ev_i,
    input  logic   rd_i,
    input  logic   wr_zero_i,
    input  logic   ack_i,
    output logic   flag_o
);
    flag_st_e st_q;
    flag_st_e st_d;
    logic     clear_w;

    assign clear_w = (wr_zero_i && (st_q == FL_ARMED)) ||
                     (ack_i && (st_q != FL_IDLE));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FL_IDLE;
        else        st_q <= st_d;
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        if (mode_i == SENSE_LOW) begin
            st_d = FL_IDLE;
        end else begin
            unique case (st_q)
                FL_IDLE: begin
                    if (ev_i) st_d = FL_PEND;
                end
                FL_PEND: begin
                    if (clear_w)   st_d = ev_i ? FL_PEND : FL_IDLE;
                    else if (rd_i) st_d = FL_ARMED;
                end
                FL_ARMED: begin
                    if (clear_w) st_d = ev_i ? FL_PEND : FL_IDLE;
                end
                default: st_d = FL_IDLE;
            endcase
        end
    end

    // Output.
    always_comb begin
        if (mode_i == SENSE_LOW) flag_o = ~lvl_i;
        else                     flag_o = (st_q != FL_IDLE);
    end

    // R6: nothing but a detected edge leaves the idle state.
    a_r6_no_set_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FL_IDLE && !ev_i) |=> (st_q == FL_IDLE));

    // R6: a pending flag that was never read survives writes.
    a_r6_pend_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FL_PEND && !ack_i && mode_i != SENSE_LOW) |=> (st_q != FL_IDLE));

    // R3: low-level mode keeps the edge machine parked.
    a_r3_level_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_LOW) |=> (st_q == FL_IDLE));

    // R7: acknowledge without a colliding edge clears the flag.
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != SENSE_LOW && ack_i && st_q != FL_IDLE && !ev_i) |=> (st_q == FL_IDLE));

endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
    parameter int N_PINS = 4,
    localparam int DW = 2 * N_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [N_PINS-1:0] flags_i,
    input  logic [N_PINS-1:0] lvl_i,
    output logic [DW-1:0]     ctrl_o,
    output logic              ctrl_wr_o,
    output logic              rd_status_o,
    output logic [N_PINS-1:0] wr_zero_o,
    output logic [DW-1:0]     reg_rdata
);
    logic [DW-1:0] ctrl_q;

    assign ctrl_wr_o   = reg_wr && !reg_sel;
    assign rd_status_o = reg_rd && reg_sel;

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_wz
            assign wr_zero_o[i] = reg_wr && reg_sel && !reg_wdata[i];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (ctrl_wr_o) ctrl_q <= reg_wdata;
    end

    assign ctrl_o    = ctrl_q;
    assign reg_rdata = reg_sel ? {lvl_i, flags_i} : ctrl_q;

    // R9: the control register holds unless written.
    a_r9_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_o |=> $stable(ctrl_q));

    // R9: a control write lands on the next edge.
    a_r9_ctrl_loads: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_o |=> (ctrl_q == $past(reg_wdata)));

endmodule

// File: rtl/irq_sense_top.sv
module irq_sense_top
    import irq_sense_pkg::*;
#(
    parameter int N_PINS = 4,
    localparam int DW = 2 * N_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [N_PINS-1:0] ack_i,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [N_PINS-1:0] irq_o
);
    logic [N_PINS-1:0] lvl_w;
    logic [N_PINS-1:0] ev_w;
    logic [N_PINS-1:0] flag_w;
    logic [N_PINS-1:0] wr_zero_w;
    logic [DW-1:0]     ctrl_w;
    logic              ctrl_wr_w;
    logic              rd_status_w;

    irq_sync #(.N_PINS(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .sync_o (lvl_w)
    );

    irq_edge_det #(.N_PINS(N_PINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_w),
        .mode_i (ctrl_w),
        .ev_o   (ev_w)
    );

    irq_regs #(.N_PINS(N_PINS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_sel     (reg_sel),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_wdata   (reg_wdata),
        .flags_i     (flag_w),
        .lvl_i       (lvl_w),
        .ctrl_o      (ctrl_w),
        .ctrl_wr_o   (ctrl_wr_w),
        .rd_status_o (rd_status_w),
        .wr_zero_o   (wr_zero_w),
        .reg_rdata   (reg_rdata)
    );

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            irq_flag_fsm u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .mode_i    (sense_e'(ctrl_w[2*i +: 2])),
                .lvl_i     (lvl_w[i]),
                .ev_i      (ev_w[i]),
                .rd_i      (rd_status_w),
                .wr_zero_i (wr_zero_w[i]),
                .ack_i     (ack_i[i]),
                .flag_o    (flag_w[i])
            );

            // R8: a detected edge always leaves the request raised.
            a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_w[i] && ctrl_w[2*i +: 2] != 2'b00 && !ctrl_wr_w) |=> irq_o[i]);

            // R3: in low-level mode the request tracks the synchronized pin.
            a_r3_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_w[2*i +: 2] == 2'b00) |-> (irq_o[i] == !reg_rdata_lvl(i)));
        end
    endgenerate

    function automatic logic reg_rdata_lvl(input int idx);
        return lvl_w[idx];
    endfunction

    assign irq_o = flag_w;

endmodule

// File: tb/irq_sense_top_tb_top.sv
module irq_sense_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pin_i;
    logic [3:0] ack_i;
    logic       reg_sel;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [3:0] irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_sense_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .ack_i     (ack_i),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    // Behavioural reference: 0 idle, 1 pending, 2 read-as-one.
    int m_s1 [4];
    int m_s2 [4];
    int m_prev [4];
    int m_st [4];
    int m_ctrl;

    function automatic int m_mode(input int n);
        return (m_ctrl >> (2*n)) & 3;
    endfunction

    function automatic logic [3:0] m_irq();
        logic [3:0] r;
        for (int n = 0; n < 4; n++)
            r[n] = (m_mode(n) == 0) ? (m_s2[n] == 0) : (m_st[n] != 0);
        return r;
    endfunction

    function automatic logic [7:0] m_rdata(input logic sel);
        logic [3:0] lv;
        for (int n = 0; n < 4; n++) lv[n] = (m_s2[n] != 0);
        return sel ? {lv, m_irq()} : 8'(m_ctrl);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0;
            for (int n = 0; n < 4; n++) begin
                m_s1[n] = 1; m_s2[n] = 1; m_prev[n] = 1; m_st[n] = 0;
            end
        end else begin
            for (int n = 0; n < 4; n++) begin
                int  md;
                bit  ev;
                bit  clr;
                md  = m_mode(n);
                ev  = (md == 1 && m_prev[n] == 1 && m_s2[n] == 0) ||
                      (md == 2 && m_prev[n] == 0 && m_s2[n] == 1) ||
                      (md == 3 && m_prev[n] != m_s2[n]);
                clr = (m_st[n] == 2 && reg_wr && reg_sel && !reg_wdata[n]) ||
                      (m_st[n] != 0 && ack_i[n]);
                if (md == 0)                             m_st[n] = 0;
                else if (clr)                            m_st[n] = ev ? 1 : 0;
                else if (reg_rd && reg_sel && m_st[n] == 1) m_st[n] = 2;
                else if (ev && m_st[n] == 0)             m_st[n] = 1;
                m_prev[n] = m_s2[n];
                m_s2[n]   = m_s1[n];
                m_s1[n]   = pin_i[n];
            end
            if (reg_wr && !reg_sel) m_ctrl = reg_wdata;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference (R10).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            check("R10 irq", {4'h0, irq_o}, {4'h0, m_irq()});
            check("R10 rdata", reg_rdata, m_rdata(reg_sel));
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0; reg_sel = 1'b1;
    endtask

    task automatic rd_status();
        reg_sel = 1'b1; reg_rd = 1'b1;
        tick(1);
        reg_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act_sel, input logic [7:0] exp);
        @(negedge clk);
        check(tag, act_sel, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin_i = 4'hF; ack_i = 4'h0;
        reg_sel = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 irq", {4'h0, irq_o}, 8'h00);
        check("R1 status", reg_rdata, 8'hF0);
        reg_sel = 1'b0;
        #1 check("R1 ctrl", reg_rdata, 8'h00);
        reg_sel = 1'b1;

        // R3 low-level mode
        tick(1);
        pin_i[0] = 1'b0;
        tick(2);
        @(negedge clk); check("R3 level set", {4'h0, irq_o}, 8'h01);
        tick(1);
        wr_reg(1'b1, 8'h00);
        ack_i = 4'hF; tick(1); ack_i = 4'h0;
        @(negedge clk); check("R3 not clearable", {4'h0, irq_o}, 8'h01);
        tick(1);
        pin_i[0] = 1'b1;
        tick(2);
        @(negedge clk); check("R3 level released", {4'h0, irq_o}, 8'h00);

        // R2 synchronizer depth
        tick(1);
        pin_i[1] = 1'b0;
        tick(1);
        @(negedge clk); check("R2 one edge", reg_rdata, 8'hF0);
        tick(1);
        @(negedge clk); check("R2 two edges", reg_rdata, 8'hD2);
        tick(1);
        pin_i[1] = 1'b1;
        tick(3);

        // R9 control readback: pin0 fall, pin1 rise, pin2 both, pin3 low
        wr_reg(1'b0, 8'h39);
        reg_sel = 1'b0;
        @(negedge clk); check("R9 ctrl", reg_rdata, 8'h39);
        reg_sel = 1'b1;

        // R4 edge modes
        tick(1);
        pin_i[0] = 1'b0; tick(3);
        @(negedge clk); check("R4 falling", {4'h0, irq_o}, 8'h01);
        tick(1);
        pin_i[1] = 1'b0; tick(3);
        @(negedge clk); check("R4 rising ignores fall", {4'h0, irq_o}, 8'h01);
        tick(1);
        pin_i[1] = 1'b1; tick(3);
        @(negedge clk); check("R4 rising", {4'h0, irq_o}, 8'h03);
        tick(1);
        pin_i[2] = 1'b0; tick(3);
        @(negedge clk); check("R4 both", {4'h0, irq_o}, 8'h07);
        check("R10 status", reg_rdata, 8'hA7);

        // R6 writes without a prior read
        tick(1);
        wr_reg(1'b1, 8'h00);
        @(negedge clk); check("R6 write0 unread", {4'h0, irq_o}, 8'h07);
        tick(1);
        wr_reg(1'b1, 8'h0F);
        @(negedge clk); check("R6 write1", {4'h0, irq_o}, 8'h07);

        // R5 read then write 0
        tick(1);
        rd_status();
        wr_reg(1'b1, 8'h00);
        @(negedge clk); check("R5 cleared", {4'h0, irq_o}, 8'h00);

        // R7 acknowledge
        tick(1);
        pin_i[0] = 1'b1; tick(3);
        @(negedge clk); check("R4 falling ignores rise", {4'h0, irq_o}, 8'h00);
        tick(1);
        pin_i[0] = 1'b0; tick(3);
        @(negedge clk); check("R7 before ack", {4'h0, irq_o}, 8'h01);
        tick(1);
        ack_i = 4'b0001; tick(1); ack_i = 4'h0;
        @(negedge clk); check("R7 ack cleared", {4'h0, irq_o}, 8'h00);

        // R8 edge colliding with clear
        tick(1);
        pin_i[2] = 1'b1; tick(3);
        @(negedge clk); check("R8 setup", {4'h0, irq_o}, 8'h04);
        tick(1);
        rd_status();
        pin_i[2] = 1'b0;
        tick(2);
        wr_reg(1'b1, 8'h00);
        @(negedge clk); check("R8 set wins", {4'h0, irq_o}, 8'h04);
        tick(1);
        wr_reg(1'b1, 8'h00);
        @(negedge clk); check("R8 back to pending", {4'h0, irq_o}, 8'h04);
        tick(1);
        rd_status();
        wr_reg(1'b1, 8'h00);
        @(negedge clk); check("R5 clear after collision", {4'h0, irq_o}, 8'h00);

        // R3 return to low-level mode: pins 0 and 2 are low
        tick(1);
        wr_reg(1'b0, 8'h00);
        @(negedge clk); check("R3 mode back to level", {4'h0, irq_o}, 8'h05);

        tick(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule